// File: doc/BRIEF.md
# PHY Ready Watchdog Timer

This block watches the ready indication of a serial storage PHY from inside the link layer. While the PHY reports ready, nothing happens. Once ready drops, a down counter starts on the transmit clock. If ready stays low until the counter runs out, the block sends the PHY a reset request one clock wide. That reset restarts the out-of-band initialisation handshake.

The timeout comes from a ten-bit configuration field. The block places nine zero bits below this field, so the count is nineteen bits long and the timeout is field × 512 transmit clocks. An enable input arms the mechanism. A field value of zero also disarms it, rather than firing at once. If ready stays low after an expiry, the counter reloads and keeps firing at the same interval. A sticky flag records that at least one expiry has taken place since reset.

Top module: `phy_rdy_watchdog`

## Requirements
- R1: During and just after a synchronous active-low reset, the reset request and the sticky flag are both 0.
- R2: With enable set and a non-zero field F, ready falling before clock edge 1 gives a reset request that is visible right after edge F×512 and not earlier. The reload value is F placed above nine zero bits.
- R3: While ready is high the counter reloads on every edge. Any ready-high cycle therefore restarts a full timeout of F×512 low edges.
- R4: The reset request lasts exactly one clock cycle per expiry.
- R5: While ready stays low, expiries repeat every F×512 clocks, and each one produces a fresh one-cycle request.
- R6: With enable clear, no reset request is issued. Clearing enable for one cycle in the middle of a count restarts the full timeout.
- R7: A field value of 0 issues no reset request, however long ready stays low.
- R8: The sticky flag goes to 1 in the cycle after the first reset request and then stays 1 until reset, whatever ready does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_timeout | input | 10 | Timeout field; count = field × 512 clocks; 0 disarms |
| cfg_enable | input | 1 | Arms the watchdog when 1 |
| phy_ready | input | 1 | PHY ready indication, active high |
| phy_reset_req | output | 1 | One-cycle request to reset the PHY |
| timeout_seen | output | 1 | Sticky flag, set by the first expiry since reset |

## Verification
A counter stuck at a bad value or a wrong reload shows up as a reset request at the wrong cycle. This can be seen as early as the first expiry, which is 512 clocks after ready falls for the smallest non-zero field. A missed reload on a ready-high cycle or an enable-low cycle moves the following request earlier by the number of cycles already counted, so one glitch in the middle of a count exposes it. A control path that ignores disarming shows up as a request within one timeout period of a disabled or zero-field run. A flag that is not sticky shows up at the first sample taken after ready returns high.

// File: rtl/phy_wd_pkg.sv
// Package: shared widths and the counter action code for the PHY ready
// watchdog. Assumes every module takes its widths from these defaults
// unless the top module overrides them.
package phy_wd_pkg;

    localparam int unsigned WD_FIELD_W = 10;  // timeout field width
    localparam int unsigned WD_SHIFT   = 9;   // zero bits below the field

    // What the counter does on the next edge
    typedef enum logic [1:0] {
        WD_LOAD   = 2'd0,   // take the reload value
        WD_DEC    = 2'd1,   // count down by one
        WD_EXPIRE = 2'd2    // last count: reload and raise the request
    } wd_act_e;

endpackage

// File: rtl/phy_wd_ctrl.sv
// Module: decides each cycle whether the counter loads, decrements or
// expires. Assumes `last` is high when the count holds its final unit.
module phy_wd_ctrl
    import phy_wd_pkg::*;
#(
    parameter int unsigned FIELD_W = WD_FIELD_W
) (
    input  logic [FIELD_W-1:0] field,
    input  logic               enable,
    input  logic               ready,
    input  logic               last,
    output wd_act_e            act
);

    logic armed;

    // Armed only with enable set and a non-zero field
    always_comb armed = enable && (field != '0);

    // Pick the counter action: hold off while disarmed or ready
    always_comb begin
        if (!armed || ready) begin
            act = WD_LOAD;
        end else if (last) begin
            act = WD_EXPIRE;
        end else begin
            act = WD_DEC;
        end
    end

endmodule

// File: rtl/phy_wd_counter.sv
// Module: down counter of the watchdog. Holds the remaining number of
// ready-low edges. Assumes the reload value is non-zero whenever the
// action is DEC or EXPIRE.
module phy_wd_counter
    import phy_wd_pkg::*;
#(
    parameter int unsigned CNT_W = WD_FIELD_W + WD_SHIFT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] reload,
    input  wd_act_e          act,
    output logic             last
);

    logic [CNT_W-1:0] count;

    // Load, count down or reload after expiry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= reload;
        end else begin
            case (act)
                WD_DEC:  count <= count - CNT_W'(1);
                default: count <= reload;
            endcase
        end
    end

    // Flag the final unit so the next low edge expires
    always_comb last = (count == CNT_W'(1));

endmodule

// File: rtl/phy_wd_report.sv
// Module: registers the one-cycle PHY reset request and the sticky
// expiry flag. Assumes `expire` is high for one cycle per timeout.
module phy_wd_report (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    output logic req,
    output logic seen
);

    // Register the request so it is glitch-free and one cycle wide
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req <= 1'b0;
        end else begin
            req <= expire;
        end
    end

    // Set the sticky flag on the first request, clear only by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen <= 1'b0;
        end else if (req) begin
            seen <= 1'b1;
        end
    end

endmodule

// File: rtl/phy_rdy_watchdog.sv
// Module: PHY ready watchdog, top level. Counts transmit clocks while the
// PHY ready input is low and asks for a PHY reset once the timeout
// (field x 2^SHIFT) has run out. Assumes the configuration inputs are
// already synchronous to clk.
module phy_rdy_watchdog
    import phy_wd_pkg::*;
#(
    parameter int unsigned FIELD_W = WD_FIELD_W,
    parameter int unsigned SHIFT   = WD_SHIFT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FIELD_W-1:0] cfg_timeout,
    input  logic               cfg_enable,
    input  logic               phy_ready,
    output logic               phy_reset_req,
    output logic               timeout_seen
);

    localparam int unsigned CNT_W = FIELD_W + SHIFT;

    logic [CNT_W-1:0] reload;
    logic             last;
    wd_act_e          act;

    // Place the field above SHIFT zero bits
    always_comb reload = {cfg_timeout, {SHIFT{1'b0}}};

    phy_wd_ctrl #(.FIELD_W(FIELD_W)) u_ctrl (
        .field  (cfg_timeout),
        .enable (cfg_enable),
        .ready  (phy_ready),
        .last   (last),
        .act    (act)
    );

    phy_wd_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .reload (reload),
        .act    (act),
        .last   (last)
    );

    phy_wd_report u_rep (
        .clk    (clk),
        .rst_n  (rst_n),
        .expire (act == WD_EXPIRE),
        .req    (phy_reset_req),
        .seen   (timeout_seen)
    );

endmodule

// File: rtl/phy_rdy_watchdog_chk.sv
// Module: property checker for the PHY ready watchdog, bound to the top.
// Assumes the port behaviour stated in the brief's requirements.
module phy_rdy_watchdog_chk #(
    parameter int unsigned FIELD_W = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic [FIELD_W-1:0] cfg_timeout,
    input logic               cfg_enable,
    input logic               phy_ready,
    input logic               phy_reset_req,
    input logic               timeout_seen
);

    // R1: reset clears both outputs
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!phy_reset_req && !timeout_seen));

    // R3: a ready-high cycle never leads to a request
    a_r3_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
        phy_ready |=> !phy_reset_req);

    // R4: request is a single cycle
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        phy_reset_req |=> !phy_reset_req);

    // R6: disabled watchdog stays quiet
    a_r6_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> !phy_reset_req);

    // R7: zero field stays quiet
    a_r7_zero_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_timeout == '0) |=> !phy_reset_req);

    // R8: the request sets the flag, and the flag holds
    a_r8_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        phy_reset_req |=> timeout_seen);

    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_seen |=> timeout_seen);

endmodule

bind phy_rdy_watchdog phy_rdy_watchdog_chk #(.FIELD_W(FIELD_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_timeout   (cfg_timeout),
    .cfg_enable    (cfg_enable),
    .phy_ready     (phy_ready),
    .phy_reset_req (phy_reset_req),
    .timeout_seen  (timeout_seen)
);

// File: tb/phy_rdy_watchdog_test.sv
// Bench: directed scenarios for the PHY ready watchdog; inputs change on
// the falling edge, outputs are sampled on the falling edge.
module phy_rdy_watchdog_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] cfg_timeout = 10'd1;
    logic       cfg_enable = 1'b0;
    logic       phy_ready = 1'b1;
    logic       phy_reset_req;
    logic       timeout_seen;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    phy_rdy_watchdog uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_timeout   (cfg_timeout),
        .cfg_enable    (cfg_enable),
        .phy_ready     (phy_ready),
        .phy_reset_req (phy_reset_req),
        .timeout_seen  (timeout_seen)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Count falling edges until a request is seen; returns -1 past limit
    task automatic wait_req(input int limit, output int n);
        n = -1;
        for (int i = 1; i <= limit; i++) begin
            @(negedge clk);
            if (phy_reset_req) begin
                n = i;
                break;
            end
        end
    endtask

    // Count requests over a number of cycles
    task automatic count_reqs(input int cycles, output int n);
        n = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (phy_reset_req) n++;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        phy_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // R1: outputs clear after reset
    task automatic t_reset();
        do_reset();
        check(phy_reset_req == 1'b0, "R1 req after reset", phy_reset_req, 0);
        check(timeout_seen == 1'b0, "R1 flag after reset", timeout_seen, 0);
    endtask

    // R2, R4, R5, R8: first expiry timing, pulse width, repeat
    task automatic t_expiry(input int field);
        int n;
        int exp;
        exp = field * 512;
        cfg_timeout = 10'(field);
        cfg_enable = 1'b1;
        phy_ready = 1'b1;
        repeat (2) @(negedge clk);
        phy_ready = 1'b0;
        wait_req(exp + 20, n);
        check(n == exp, "R2 first expiry cycle", n, exp);
        @(negedge clk);
        check(phy_reset_req == 1'b0, "R4 pulse one cycle", phy_reset_req, 0);
        check(timeout_seen == 1'b1, "R8 flag set", timeout_seen, 1);
        wait_req(exp + 20, n);
        check(n == exp - 1, "R5 repeat interval", n + 1, exp);
        @(negedge clk);
        check(phy_reset_req == 1'b0, "R4 repeat pulse one cycle", phy_reset_req, 0);
        phy_ready = 1'b1;
        repeat (3) @(negedge clk);
        check(timeout_seen == 1'b1, "R8 flag held with ready high", timeout_seen, 1);
    endtask

    // R3: a one-cycle ready glitch restarts the count
    task automatic t_ready_glitch();
        int n;
        cfg_timeout = 10'd1;
        cfg_enable = 1'b1;
        phy_ready = 1'b1;
        repeat (2) @(negedge clk);
        phy_ready = 1'b0;
        count_reqs(300, n);
        check(n == 0, "R3 no early request", n, 0);
        phy_ready = 1'b1;
        @(negedge clk);
        phy_ready = 1'b0;
        wait_req(600, n);
        check(n == 512, "R3 full restart after ready", n, 512);
        phy_ready = 1'b1;
        @(negedge clk);
    endtask

    // R6: disabled quiet, and disable glitch restarts the count
    task automatic t_disable();
        int n;
        cfg_timeout = 10'd1;
        cfg_enable = 1'b0;
        phy_ready = 1'b0;
        count_reqs(1600, n);
        check(n == 0, "R6 no request while disabled", n, 0);
        phy_ready = 1'b1;
        cfg_enable = 1'b1;
        repeat (2) @(negedge clk);
        phy_ready = 1'b0;
        count_reqs(300, n);
        check(n == 0, "R6 no request before disable glitch", n, 0);
        cfg_enable = 1'b0;
        @(negedge clk);
        cfg_enable = 1'b1;
        wait_req(600, n);
        check(n == 512, "R6 full restart after enable glitch", n, 512);
        phy_ready = 1'b1;
        @(negedge clk);
    endtask

    // R7: zero field never fires
    task automatic t_zero_field();
        int n;
        cfg_timeout = 10'd0;
        cfg_enable = 1'b1;
        phy_ready = 1'b0;
        count_reqs(1600, n);
        check(n == 0, "R7 no request with zero field", n, 0);
        phy_ready = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_expiry(1);
        do_reset();
        check(timeout_seen == 1'b0, "R8 flag cleared only by reset", timeout_seen, 0);
        t_expiry(2);
        t_ready_glitch();
        t_disable();
        t_zero_field();
        t_reset();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule